// File: doc/BRIEF.md
# Four-Channel Converter Code Register Bank with Simultaneous Update

This block sits on an 8-bit processor bus and holds the digital codes for four 12-bit converter channels. Each channel has a staging register, filled by two byte writes at a pair of adjacent addresses, and an output register that feeds the converter. Writes to the staging registers never move an output. The outputs move only on an update event, and when one comes all four take their staged values on the same clock edge, so several channels can be retargeted without intermediate glitches between them.

An update event comes from a write to the broadcast half of the address space. An optional mode also raises it on the write that fills the high byte of the fourth channel, so software that always writes channels in order needs no separate broadcast write. A format input selects how a 12-bit code is split across the two bytes: right-justified, with the spare bits at the top of the high byte, or left-justified, with the spare bits at the bottom of the low byte. Base-address decoding lies outside the block and arrives as a chip select.

Top module: `quad_dac_bank`

## Requirements
- R1: With `bus_addr[3]`=0, `bus_addr[2:1]` picks the channel: value k picks channel k+1, whose code appears on `ch_codes[12k+11:12k]`. `bus_addr[0]`=0 selects the low byte and `bus_addr[0]`=1 selects the high byte of that channel. Example: address 4'b0011 is the high byte of channel 2.
- R2: A write is accepted on a rising clock edge only when `cs`=1 and `wr_n`=0. Any other combination leaves every staging and output register unchanged.
- R3: An accepted write with `bus_addr[3]`=1 loads all four output registers from their staging registers on the same edge. `bus_addr[2:0]` and `bus_data` are ignored, and no staging register changes.
- R4: With `fmt_left`=0 (right-justified), a high-byte write sets code bits 11:8 from `bus_data[3:0]` and ignores `bus_data[7:4]`. A low-byte write sets code bits 7:0 from `bus_data[7:0]`. The other bits of the staged code keep their values.
- R5: With `fmt_left`=1 (left-justified), a high-byte write sets code bits 11:4 from `bus_data[7:0]`. A low-byte write sets code bits 3:0 from `bus_data[7:4]` and ignores `bus_data[3:0]`. The other bits of the staged code keep their values.
- R6: An output register changes only on an update event (R3 or R7). Staging writes leave every output as it was.
- R7: With `auto_update`=1, an accepted write to address 4'b0111 stores its byte and, on the same edge, loads all four outputs from the staging registers including that byte. With `auto_update`=0, the same write does not change any output.
- R8: Synchronous reset (`rst`=1) clears every staging and output register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are taken on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select from the external base-address decoder, active high |
| wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 4 | Register address: bit 3 selects broadcast, bits 2:0 select the channel byte |
| bus_data | input | 8 | Write data byte |
| fmt_left | input | 1 | 0 = right-justified byte split, 1 = left-justified byte split |
| auto_update | input | 1 | 1 = the high-byte write of channel 4 also updates all outputs |
| ch_codes | output | 48 | Four 12-bit output codes; channel 1 in bits 11:0 |

## Verification
Each of the four channels is given a distinct code in the right-justified format and then in the left-justified format. The spare nibble of each byte is filled with a non-zero value, so a design that takes the wrong nibble or crosses channels produces a mismatch on the exact channel involved. The outputs are sampled after every staging write and then after a broadcast sent with non-zero low address bits, which separates "held until the update" from "loaded early" and checks that bits 2:0 are ignored on a broadcast. Further patterns cover a lone high-byte write that must keep the low bits, writes blocked by either control, and the automatic update both enabled and disabled. The automatic-update pattern also shows whether the byte written on the triggering edge reaches the outputs.

// File: rtl/qd_pkg.sv
package qd_pkg;

    parameter int unsigned NCH    = 4;
    parameter int unsigned CODE_W = 12;
    parameter int unsigned BYTE_W = 8;
    parameter int unsigned ADDR_W = 4;

    localparam int unsigned CH_IDX_W = $clog2(NCH);
    localparam int unsigned HI_W     = CODE_W - BYTE_W;
    localparam int unsigned FLAT_W   = NCH * CODE_W;
    localparam int unsigned BCAST_BIT = ADDR_W - 1;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        FMT_RIGHT = 1'b0,
        FMT_LEFT  = 1'b1
    } fmt_e;

    // one decoded bus access
    typedef struct packed {
        logic                valid;
        logic                bcast;
        logic [CH_IDX_W-1:0] chan;
        logic                hi;
        byte_t               data;
    } bus_wr_t;

    // merge one byte into a staged code according to the selected split
    function automatic code_t merge_byte(code_t cur, logic hi, fmt_e fmt, byte_t d);
        code_t r;
        if (fmt == FMT_RIGHT) begin
            if (hi) r = {d[HI_W-1:0], cur[BYTE_W-1:0]};
            else    r = {cur[CODE_W-1:BYTE_W], d};
        end else begin
            if (hi) r = {d, cur[HI_W-1:0]};
            else    r = {cur[CODE_W-1:HI_W], d[BYTE_W-1 -: HI_W]};
        end
        return r;
    endfunction

endpackage

// File: rtl/qd_bus_decode.sv
module qd_bus_decode
    import qd_pkg::*;
(
    input  logic              cs,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  byte_t             bus_data,
    output bus_wr_t           wr
);

    always_comb begin
        wr.valid = cs & ~wr_n;
        wr.bcast = bus_addr[BCAST_BIT];
        wr.chan  = bus_addr[CH_IDX_W:1];
        wr.hi    = bus_addr[0];
        wr.data  = bus_data;
    end

endmodule

// File: rtl/qd_update_ctrl.sv
module qd_update_ctrl
    import qd_pkg::*;
(
    input  logic                valid,
    input  logic                bcast,
    input  logic [CH_IDX_W-1:0] chan,
    input  logic                hi,
    input  logic                auto_en,
    output logic                update
);

    localparam logic [CH_IDX_W-1:0] LAST_CH = CH_IDX_W'(NCH - 1);

    logic last_fill;

    always_comb begin
        last_fill = ~bcast & hi & (chan == LAST_CH);
        update    = valid & (bcast | (auto_en & last_fill));
    end

endmodule

// File: rtl/qd_stage_bank.sv
module qd_stage_bank
    import qd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_wr_t           wr,
    input  fmt_e              fmt,
    output code_t [NCH-1:0]   stage_q,
    output code_t [NCH-1:0]   stage_d
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel;

        always_comb begin
            sel = wr.valid & ~wr.bcast & (wr.chan == CH_IDX_W'(i));
            stage_d[i] = sel ? merge_byte(stage_q[i], wr.hi, fmt, wr.data)
                             : stage_q[i];
        end

        always_ff @(posedge clk) begin
            if (rst) stage_q[i] <= '0;
            else     stage_q[i] <= stage_d[i];
        end
    end

endmodule

// File: rtl/qd_out_bank.sv
module qd_out_bank
    import qd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            update,
    input  code_t [NCH-1:0] stage_d,
    output code_t [NCH-1:0] out_q
);

    for (genvar i = 0; i < NCH; i++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst)         out_q[i] <= '0;
            else if (update) out_q[i] <= stage_d[i];
        end
    end

endmodule

// File: rtl/quad_dac_bank.sv
module quad_dac_bank
    import qd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_data,
    input  logic              fmt_left,
    input  logic              auto_update,
    output logic [FLAT_W-1:0] ch_codes
);

    bus_wr_t          wr;
    logic             update;
    code_t [NCH-1:0]  stage_q;
    code_t [NCH-1:0]  stage_d;
    code_t [NCH-1:0]  out_q;
    logic [FLAT_W-1:0] stage_flat;

    qd_bus_decode u_dec (
        .cs       (cs),
        .wr_n     (wr_n),
        .bus_addr (bus_addr),
        .bus_data (bus_data),
        .wr       (wr)
    );

    qd_update_ctrl u_upd (
        .valid   (wr.valid),
        .bcast   (wr.bcast),
        .chan    (wr.chan),
        .hi      (wr.hi),
        .auto_en (auto_update),
        .update  (update)
    );

    qd_stage_bank u_stage (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .fmt     (fmt_e'(fmt_left)),
        .stage_q (stage_q),
        .stage_d (stage_d)
    );

    qd_out_bank u_out (
        .clk     (clk),
        .rst     (rst),
        .update  (update),
        .stage_d (stage_d),
        .out_q   (out_q)
    );

    assign stage_flat = stage_q;
    assign ch_codes   = out_q;

endmodule

// File: rtl/qd_checker.sv
module qd_checker
    import qd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs,
    input logic              wr_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_data,
    input logic              fmt_left,
    input logic              auto_update,
    input logic [FLAT_W-1:0] ch_codes,
    input logic [FLAT_W-1:0] stage_flat
);

    logic acc;
    logic bc_wr;
    logic auto_wr;
    logic upd_evt;

    assign acc     = cs && !wr_n;
    assign bc_wr   = acc && bus_addr[BCAST_BIT];
    assign auto_wr = acc && auto_update && (bus_addr == ADDR_W'(2 * NCH - 1));
    assign upd_evt = bc_wr || auto_wr;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (ch_codes == '0) && (stage_flat == '0)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(acc && !bus_addr[BCAST_BIT]) |=> $stable(stage_flat)); // R2

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !upd_evt |=> $stable(ch_codes)); // R6

    AST_BCAST_LOAD: assert property (@(posedge clk) disable iff (rst)
        bc_wr |=> (ch_codes == $past(stage_flat))); // R3

    AST_AUTO_LOAD: assert property (@(posedge clk) disable iff (rst)
        auto_wr |=> (ch_codes == stage_flat)); // R7

    for (genvar i = 0; i < NCH; i++) begin : g_fmt
        AST_RIGHT_HIGH: assert property (@(posedge clk) disable iff (rst)
            (acc && !fmt_left && bus_addr == ADDR_W'(2 * i + 1))
            |=> (stage_flat[i*CODE_W+BYTE_W +: HI_W] == $past(bus_data[HI_W-1:0]))); // R4

        AST_LEFT_HIGH: assert property (@(posedge clk) disable iff (rst)
            (acc && fmt_left && bus_addr == ADDR_W'(2 * i + 1))
            |=> (stage_flat[i*CODE_W+HI_W +: BYTE_W] == $past(bus_data))); // R5

        AST_CHAN_LOW: assert property (@(posedge clk) disable iff (rst)
            (acc && !fmt_left && bus_addr == ADDR_W'(2 * i))
            |=> (stage_flat[i*CODE_W +: BYTE_W] == $past(bus_data))); // R1
    end

endmodule

bind quad_dac_bank qd_checker u_qd_checker (
    .clk         (clk),
    .rst         (rst),
    .cs          (cs),
    .wr_n        (wr_n),
    .bus_addr    (bus_addr),
    .bus_data    (bus_data),
    .fmt_left    (fmt_left),
    .auto_update (auto_update),
    .ch_codes    (ch_codes),
    .stage_flat  (stage_flat)
);

// File: tb/test_quad_dac_bank.sv
module test_quad_dac_bank;

    localparam int NC = 4;
    localparam int WD = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b0;
    logic        wr_n = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        fmt_left = 1'b0;
    logic        auto_update = 1'b0;
    logic [47:0] ch_codes;

    int checks = 0;
    int errors = 0;

    logic [11:0] exp_stage [NC];
    logic [11:0] exp_out   [NC];

    always #4 clk = ~clk;

    quad_dac_bank i_quad_dac_bank (
        .clk         (clk),
        .rst         (rst),
        .cs          (cs),
        .wr_n        (wr_n),
        .bus_addr    (bus_addr),
        .bus_data    (bus_data),
        .fmt_left    (fmt_left),
        .auto_update (auto_update),
        .ch_codes    (ch_codes)
    );

    task automatic check(string req, logic [11:0] act, logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
        end
    endtask

    task automatic check_outs(string req);
        for (int k = 0; k < NC; k++)
            check(req, ch_codes[12*k +: 12], exp_out[k]);
    endtask

    // byte split per R4 (right) and R5 (left)
    function automatic logic [11:0] merge(logic [11:0] cur, logic hi, logic lft, logic [7:0] d);
        if (!lft) return hi ? {d[3:0], cur[7:0]} : {cur[11:8], d};
        else      return hi ? {d, cur[3:0]} : {cur[11:4], d[7:4]};
    endfunction

    task automatic bus_attempt(logic c, logic w, logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        cs = c; wr_n = w; bus_addr = a; bus_data = d;
        @(negedge clk);
        cs = 1'b0; wr_n = 1'b1; bus_data = 8'h5A;
    endtask

    task automatic bus_write(logic [3:0] a, logic [7:0] d);
        bus_attempt(1'b1, 1'b0, a, d);
        if (a[3]) begin
            for (int k = 0; k < NC; k++) exp_out[k] = exp_stage[k];
        end else begin
            exp_stage[a[2:1]] = merge(exp_stage[a[2:1]], a[0], fmt_left, d);
            if (auto_update && a[2:0] == 3'b111)
                for (int k = 0; k < NC; k++) exp_out[k] = exp_stage[k];
        end
    endtask

    // load one channel in the active format, spare nibbles filled with junk
    task automatic load_chan(int ch, logic [11:0] code, logic hi_first);
        logic [7:0] hb, lb;
        if (!fmt_left) begin
            hb = {4'hB ^ 4'(ch), code[11:8]};
            lb = code[7:0];
        end else begin
            hb = code[11:4];
            lb = {code[3:0], 4'hA ^ 4'(ch)};
        end
        if (hi_first) begin
            bus_write(4'(2*ch+1), hb); check_outs("R6");
            bus_write(4'(2*ch),   lb); check_outs("R6");
        end else begin
            bus_write(4'(2*ch),   lb); check_outs("R6");
            bus_write(4'(2*ch+1), hb); check_outs("R6");
        end
    endtask

    task automatic t_reset();
        for (int k = 0; k < NC; k++) begin exp_stage[k] = '0; exp_out[k] = '0; end
        check_outs("R8");
    endtask

    task automatic t_right();
        logic [11:0] c [NC] = '{12'hA5C, 12'h3F1, 12'h7E2, 12'hC08};
        fmt_left = 1'b0;
        for (int k = 0; k < NC; k++) load_chan(k, c[k], k[0]);
        bus_write(4'b1101, 8'hFF);
        check_outs("R3");
        for (int k = 0; k < NC; k++) check("R4 R1", ch_codes[12*k +: 12], c[k]);
    endtask

    task automatic t_left();
        logic [11:0] c [NC] = '{12'h123, 12'h9AB, 12'h4D6, 12'hFE0};
        fmt_left = 1'b1;
        for (int k = 0; k < NC; k++) load_chan(k, c[k], !k[0]);
        bus_write(4'b1000, 8'h00);
        check_outs("R3");
        for (int k = 0; k < NC; k++) check("R5 R1", ch_codes[12*k +: 12], c[k]);
    endtask

    task automatic t_partial();
        fmt_left = 1'b0;
        bus_write(4'b0011, 8'hE6);
        check_outs("R6");
        bus_write(4'b1010, 8'h33);
        check("R4", ch_codes[23:12], 12'h6AB);
        fmt_left = 1'b1;
        bus_write(4'b0100, 8'h7F);
        bus_write(4'b1111, 8'h00);
        check("R5", ch_codes[35:24], 12'h4D7);
        check_outs("R3");
    endtask

    task automatic t_strobe();
        fmt_left = 1'b0;
        bus_attempt(1'b0, 1'b0, 4'b0001, 8'h0F);
        bus_attempt(1'b1, 1'b1, 4'b0110, 8'h99);
        bus_attempt(1'b0, 1'b0, 4'b1000, 8'h00);
        bus_attempt(1'b1, 1'b1, 4'b1000, 8'h00);
        check_outs("R2");
        bus_write(4'b1000, 8'h00);
        check_outs("R2");
    endtask

    task automatic t_auto();
        logic [11:0] c [NC] = '{12'h001, 12'h800, 12'h7FF, 12'hFFF};
        fmt_left = 1'b0;
        auto_update = 1'b1;
        for (int k = 0; k < NC - 1; k++) load_chan(k, c[k], 1'b0);
        bus_write(4'b0110, c[3][7:0]);
        check_outs("R7");
        bus_write(4'b0111, {4'h0, c[3][11:8]});
        check_outs("R7");
        for (int k = 0; k < NC; k++) check("R7", ch_codes[12*k +: 12], c[k]);
        auto_update = 1'b0;
        bus_write(4'b0111, 8'h05);
        check("R7", ch_codes[47:36], 12'hFFF);
        bus_write(4'b1000, 8'h00);
        check("R3", ch_codes[47:36], 12'h5FF);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_right();
        t_left();
        t_partial();
        t_strobe();
        t_auto();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule